// File: doc/BRIEF.md
# Hop-Count Virtual Channel Class Selector

This block picks the virtual channel that a wormhole packet's header takes on one output link of a router in a recursively built, fully connected cluster network. The link's virtual channels are split into classes, and the class a packet uses depends on how far it has travelled. Each request brings the class the packet held on its previous link, a flag that marks the hop out of its source node, and a flag from the route computer that marks the chosen link as one that joins two sub-clusters. A policy input picks one of two rules. In the per-hop rule the class rises by one on every hop. In the bridge-crossing rule it rises only on hops over a joining link, so about half as many classes are needed.

Within the class it needs, the block grants the free virtual channel with the lowest index. That channel then stays reserved until the packet's tail flit on it is reported. When the class has no free channel, or the computed class lies beyond the classes of the active policy, the block raises stall and the header keeps presenting its request. For a cluster network with `LEVELS` levels, the per-hop rule uses 2^LEVELS − 1 classes and the bridge-crossing rule uses 2^(LEVELS−1). The `NUM_VC` channels of the link are shared out evenly among the classes of the active policy. The policy input must not change while any channel is reserved.

Top module: `hop_vc_selector`

## Requirements
- R1: A request with the injection flag set is given class 0, whatever the policy, the incoming class or the joining-link flag.
- R2: Under the per-hop rule (policy 0), a request without injection is given the incoming class plus one. There are 2^LEVELS − 1 classes, each with NUM_VC/(2^LEVELS − 1) channels.
- R3: Under the bridge-crossing rule (policy 1), a request without injection whose joining-link flag is 0 keeps the incoming class.
- R4: Under the bridge-crossing rule, a request without injection whose joining-link flag is 1 is given the incoming class plus one. There are 2^(LEVELS−1) classes, each with NUM_VC/2^(LEVELS−1) channels.
- R5: If the computed class is not below the class count of the active policy, nothing is granted and stall is high.
- R6: The grant goes to the lowest in-class index k whose channel is free. The physical channel number is class × (channels per class) + k.
- R7: If every channel of the computed class is reserved, grant is low and stall is high. Stall stays high while the request is held unchanged and no tail is reported.
- R8: A granted channel is reserved from the clock edge after the grant. A tail report for that channel frees it from the clock edge after the report, so a request in the same cycle as the report still sees it reserved.
- R9: After reset every channel is free. While no request is present, grant and stall are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 1 | 0: per-hop rule, 1: bridge-crossing rule |
| req_valid_i | input | 1 | Header requests a channel this cycle |
| inject_i | input | 1 | Hop leaves the packet's source node |
| flip_i | input | 1 | Selected link joins two sub-clusters |
| cls_in_i | input | CLS_W (2) | Class held on the previous link |
| tail_valid_i | input | 1 | Tail flit of a packet passes this cycle |
| tail_vc_i | input | VC_W (3) | Physical channel the tail belongs to |
| grant_valid_o | output | 1 | A channel is granted this cycle |
| grant_class_o | output | CLS_W (2) | Class of the granted channel |
| grant_vc_o | output | LVC_W (2) | Index of the granted channel within its class |
| grant_chan_o | output | VC_W (3) | Physical number of the granted channel |
| stall_o | output | 1 | Request present but no channel can be granted |

## Verification
The bench builds the block with LEVELS = 2 and NUM_VC = 6. This gives three classes of two channels under the per-hop rule and two classes of three channels under the bridge-crossing rule. Random routes in the 16-node two-level network take up to three hops with at most one joining link, so under both rules every legal class is reached. Because tails are released slowly, each class also fills up, which exercises stall and the release timing. Directed steps push the class one past the top of each policy and check the same-cycle tail case.

// File: rtl/hop_vc_pkg.sv
package hop_vc_pkg;

  typedef enum logic {
    POL_PERHOP = 1'b0,
    POL_BRIDGE = 1'b1
  } hop_policy_e;

  function automatic int perhop_classes(input int levels);
    return (1 << levels) - 1;
  endfunction

  function automatic int bridge_classes(input int levels);
    return 1 << (levels - 1);
  endfunction

endpackage

// File: rtl/hvs_class_calc.sv
module hvs_class_calc #(
  parameter int CLS_W      = 2,
  parameter int PH_CLASSES = 3,
  parameter int FH_CLASSES = 2
) (
  input  logic             policy_i,
  input  logic             inject_i,
  input  logic             flip_i,
  input  logic [CLS_W-1:0] cls_in_i,
  output logic [CLS_W:0]   cls_next_o,
  output logic             in_range_o
);
  import hop_vc_pkg::*;

  hop_policy_e pol;
  logic [CLS_W:0] limit;

  always_comb begin
    pol = hop_policy_e'(policy_i);
    if (inject_i) begin
      cls_next_o = '0;
    end else if (pol == POL_PERHOP) begin
      cls_next_o = {1'b0, cls_in_i} + 1'b1;
    end else begin
      cls_next_o = {1'b0, cls_in_i} + {{CLS_W{1'b0}}, flip_i};
    end
    limit      = (pol == POL_PERHOP) ? (CLS_W+1)'(PH_CLASSES) : (CLS_W+1)'(FH_CLASSES);
    in_range_o = (cls_next_o < limit);
  end

endmodule

// File: rtl/hvs_vc_pick.sv
module hvs_vc_pick #(
  parameter int NUM_VC = 6,
  parameter int VC_W   = 3,
  parameter int LVC_W  = 2,
  parameter int CLS_W  = 2,
  parameter int PH_PER = 2,
  parameter int FH_PER = 3
) (
  input  logic              policy_i,
  input  logic [CLS_W:0]    cls_i,
  input  logic [NUM_VC-1:0] resv_i,
  output logic              found_o,
  output logic [LVC_W-1:0]  lvc_o,
  output logic [VC_W-1:0]   chan_o
);
  localparam int MAX_PER = (FH_PER > PH_PER) ? FH_PER : PH_PER;
  localparam int BW      = VC_W + CLS_W + 2;

  logic [BW-1:0]      per_cnt;
  logic [BW-1:0]      base;
  logic [MAX_PER-1:0] slot_ok;

  always_comb begin
    per_cnt = policy_i ? BW'(FH_PER) : BW'(PH_PER);
    base    = BW'(cls_i) * per_cnt;
  end

  for (genvar j = 0; j < MAX_PER; j++) begin : g_slot
    logic [BW-1:0] idx;
    always_comb begin
      idx        = base + BW'(j);
      slot_ok[j] = (BW'(j) < per_cnt) && (idx < BW'(NUM_VC)) &&
                   !resv_i[idx[VC_W-1:0]];
    end
  end

  always_comb begin
    found_o = 1'b0;
    lvc_o   = '0;
    for (int k = MAX_PER - 1; k >= 0; k--) begin
      if (slot_ok[k]) begin
        found_o = 1'b1;
        lvc_o   = LVC_W'(k);
      end
    end
    chan_o = VC_W'(base + BW'(lvc_o));
  end

endmodule

// File: rtl/hvs_resv_reg.sv
module hvs_resv_reg #(
  parameter int NUM_VC = 6,
  parameter int VC_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en_i,
  input  logic [VC_W-1:0]   set_idx_i,
  input  logic              clr_en_i,
  input  logic [VC_W-1:0]   clr_idx_i,
  output logic [NUM_VC-1:0] resv_o
);
  logic [NUM_VC-1:0] resv_q;
  logic [NUM_VC-1:0] resv_d;
  logic              upd_en;

  always_comb begin
    upd_en = set_en_i | clr_en_i;
    resv_d = resv_q;
    if (set_en_i) resv_d[set_idx_i] = 1'b1;
    if (clr_en_i) resv_d[clr_idx_i] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_q <= '0;
    end else if (upd_en) begin
      resv_q <= resv_d;
    end
  end

  assign resv_o = resv_q;

endmodule

// File: rtl/hop_vc_selector.sv
module hop_vc_selector #(
  parameter  int LEVELS     = 2,
  parameter  int NUM_VC     = 6,
  localparam int PH_CLASSES = hop_vc_pkg::perhop_classes(LEVELS),
  localparam int FH_CLASSES = hop_vc_pkg::bridge_classes(LEVELS),
  localparam int PH_PER     = NUM_VC / PH_CLASSES,
  localparam int FH_PER     = NUM_VC / FH_CLASSES,
  localparam int CLS_W      = $clog2(PH_CLASSES + 1),
  localparam int VC_W       = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int LVC_W      = (FH_PER > 1) ? $clog2(FH_PER) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             policy_i,
  input  logic             req_valid_i,
  input  logic             inject_i,
  input  logic             flip_i,
  input  logic [CLS_W-1:0] cls_in_i,
  input  logic             tail_valid_i,
  input  logic [VC_W-1:0]  tail_vc_i,
  output logic             grant_valid_o,
  output logic [CLS_W-1:0] grant_class_o,
  output logic [LVC_W-1:0] grant_vc_o,
  output logic [VC_W-1:0]  grant_chan_o,
  output logic             stall_o
);
  logic [CLS_W:0]    cls_next;
  logic              in_range;
  logic              found;
  logic [NUM_VC-1:0] resv_q;

  hvs_class_calc #(
    .CLS_W(CLS_W), .PH_CLASSES(PH_CLASSES), .FH_CLASSES(FH_CLASSES)
  ) u_calc (
    .policy_i  (policy_i),
    .inject_i  (inject_i),
    .flip_i    (flip_i),
    .cls_in_i  (cls_in_i),
    .cls_next_o(cls_next),
    .in_range_o(in_range)
  );

  hvs_vc_pick #(
    .NUM_VC(NUM_VC), .VC_W(VC_W), .LVC_W(LVC_W), .CLS_W(CLS_W),
    .PH_PER(PH_PER), .FH_PER(FH_PER)
  ) u_pick (
    .policy_i(policy_i),
    .cls_i   (cls_next),
    .resv_i  (resv_q),
    .found_o (found),
    .lvc_o   (grant_vc_o),
    .chan_o  (grant_chan_o)
  );

  always_comb begin
    grant_valid_o = req_valid_i & in_range & found;
    stall_o       = req_valid_i & ~(in_range & found);
    grant_class_o = cls_next[CLS_W-1:0];
  end

  hvs_resv_reg #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_resv (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en_i (grant_valid_o),
    .set_idx_i(grant_chan_o),
    .clr_en_i (tail_valid_i),
    .clr_idx_i(tail_vc_i),
    .resv_o   (resv_q)
  );

endmodule

// File: rtl/hvs_checker.sv
module hvs_checker #(
  parameter  int LEVELS     = 2,
  parameter  int NUM_VC     = 6,
  localparam int PH_CLASSES = hop_vc_pkg::perhop_classes(LEVELS),
  localparam int FH_CLASSES = hop_vc_pkg::bridge_classes(LEVELS),
  localparam int PH_PER     = NUM_VC / PH_CLASSES,
  localparam int FH_PER     = NUM_VC / FH_CLASSES,
  localparam int CLS_W      = $clog2(PH_CLASSES + 1),
  localparam int VC_W       = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int LVC_W      = (FH_PER > 1) ? $clog2(FH_PER) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              policy_i,
  input logic              req_valid_i,
  input logic              inject_i,
  input logic              flip_i,
  input logic [CLS_W-1:0]  cls_in_i,
  input logic              tail_valid_i,
  input logic [VC_W-1:0]   tail_vc_i,
  input logic              grant_valid_o,
  input logic [CLS_W-1:0]  grant_class_o,
  input logic [LVC_W-1:0]  grant_vc_o,
  input logic [VC_W-1:0]   grant_chan_o,
  input logic              stall_o,
  input logic [NUM_VC-1:0] resv_q
);
  logic [CLS_W:0] max_cls;
  logic [CLS_W:0] cls_plus1;
  int             per_cnt;

  always_comb begin
    max_cls   = policy_i ? (CLS_W+1)'(FH_CLASSES - 1) : (CLS_W+1)'(PH_CLASSES - 1);
    cls_plus1 = {1'b0, cls_in_i} + 1'b1;
    per_cnt   = policy_i ? FH_PER : PH_PER;
  end

  a_r1_inject_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && inject_i) |-> (grant_class_o == '0));

  a_r2_perhop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && !inject_i && !policy_i) |-> ({1'b0, grant_class_o} == cls_plus1));

  a_r3_bridge_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && !inject_i && policy_i && !flip_i) |-> (grant_class_o == cls_in_i));

  a_r4_bridge_step: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && !inject_i && policy_i && flip_i) |-> ({1'b0, grant_class_o} == cls_plus1));

  a_r5_class_bound: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> ({1'b0, grant_class_o} <= max_cls));

  a_r6_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> (!resv_q[grant_chan_o] &&
      (int'(grant_chan_o) == int'(grant_class_o) * per_cnt + int'(grant_vc_o))));

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !tail_valid_i) |=>
      (!(req_valid_i && $stable(cls_in_i) && $stable(inject_i) &&
         $stable(flip_i) && $stable(policy_i)) || stall_o));

  a_r8_reserve_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |=> resv_q[$past(grant_chan_o)]);

  a_r8_release_on_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_valid_i && !(grant_valid_o && grant_chan_o == tail_vc_i)) |=>
      !resv_q[$past(tail_vc_i)]);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |-> (!grant_valid_o && !stall_o));

endmodule

bind hop_vc_selector hvs_checker #(.LEVELS(LEVELS), .NUM_VC(NUM_VC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .policy_i     (policy_i),
  .req_valid_i  (req_valid_i),
  .inject_i     (inject_i),
  .flip_i       (flip_i),
  .cls_in_i     (cls_in_i),
  .tail_valid_i (tail_valid_i),
  .tail_vc_i    (tail_vc_i),
  .grant_valid_o(grant_valid_o),
  .grant_class_o(grant_class_o),
  .grant_vc_o   (grant_vc_o),
  .grant_chan_o (grant_chan_o),
  .stall_o      (stall_o),
  .resv_q       (resv_q)
);

// File: tb/sim_hop_vc_selector.sv
module sim_hop_vc_selector;

  logic       clk;
  logic       rst_n;
  logic       pol;
  logic       req;
  logic       inj;
  logic       flp;
  logic [1:0] cin;
  logic       tvalid;
  logic [2:0] tvc;
  logic       grant_valid;
  logic [1:0] grant_class;
  logic [1:0] grant_vc;
  logic [2:0] grant_chan;
  logic       stall;

  hop_vc_selector #(.LEVELS(2), .NUM_VC(6)) u0 (
    .clk(clk), .rst_n(rst_n), .policy_i(pol), .req_valid_i(req),
    .inject_i(inj), .flip_i(flp), .cls_in_i(cin), .tail_valid_i(tvalid),
    .tail_vc_i(tvc), .grant_valid_o(grant_valid), .grant_class_o(grant_class),
    .grant_vc_o(grant_vc), .grant_chan_o(grant_chan), .stall_o(stall)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int  total;
  int  failed;
  bit  res[6];
  int  held[$];
  bit  last_grant;
  int  last_cls;
  int  last_chan;
  int  act_chan;
  int  act_vc;
  bit  act_stall;
  bit  act_grant;

  task automatic report();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One clock cycle: check combinational outputs against the behavioural
  // model just before the edge, then update the model's reservations.
  task automatic cycle();
    int  c, ncls, per, elvc, echan;
    bit  eg, es;
    string tg, tc;
    #4;
    eg = 0; es = 0; c = 0; elvc = 0; echan = 0;
    ncls = pol ? 2 : 3;
    per  = 6 / ncls;
    if (req) begin
      c = inj ? 0 : (pol ? int'(cin) + int'(flp) : int'(cin) + 1);
      if (c < ncls) begin
        for (int j = 0; j < per; j++) begin
          if (!eg && !res[c*per+j]) begin
            eg = 1; elvc = j; echan = c*per + j;
          end
        end
      end
      es = !eg;
    end
    tg = !req ? "R9" : ((c >= ncls) ? "R5" : "R7");
    tc = inj ? "R1" : (!pol ? "R2" : (flp ? "R4" : "R3"));
    chk(grant_valid === eg, tg, "grant_valid", int'(grant_valid), int'(eg));
    chk(stall === es, tg, "stall", int'(stall), int'(es));
    if (eg && grant_valid === 1'b1) begin
      chk(int'(grant_class) == c, tc, "class", int'(grant_class), c);
      chk(int'(grant_vc) == elvc, "R6", "vc index", int'(grant_vc), elvc);
      chk(int'(grant_chan) == echan, "R6", "channel", int'(grant_chan), echan);
    end
    act_grant = grant_valid; act_stall = stall;
    act_chan  = int'(grant_chan); act_vc = int'(grant_vc);
    last_grant = eg; last_cls = c; last_chan = echan;
    @(posedge clk);
    if (eg) res[echan] = 1;
    if (tvalid) res[tvc] = 0;
    @(negedge clk);
  endtask

  task automatic drive(input bit r, input bit i, input bit f, input int c);
    req = r; inj = i; flp = f; cin = 2'(c);
  endtask

  task automatic release_all();
    drive(0, 0, 0, 0);
    while (held.size() > 0) begin
      tvalid = 1; tvc = 3'(held.pop_front());
      cycle();
    end
    tvalid = 0;
  endtask

  task automatic maybe_tail();
    tvalid = 0;
    if (held.size() > 0 && ($urandom % 3) == 0) begin
      int k;
      k = int'($urandom % held.size());
      tvc = 3'(held[k]);
      held.delete(k);
      tvalid = 1;
    end
  endtask

  // Random routes in the 16-node two-level network with 4-node clusters.
  task automatic run_routes(input bit p, input int npkt);
    pol = p;
    for (int n = 0; n < npkt; n++) begin
      int s, t, s2, s1, t2, t1, cls_ref, flips_seen;
      bit fl[$];
      s = int'($urandom % 16);
      do t = int'($urandom % 16); while (t == s);
      s2 = s / 4; s1 = s % 4; t2 = t / 4; t1 = t % 4;
      if (s2 == t2) fl.push_back(0);
      else begin
        if (s1 != t2) fl.push_back(0);
        fl.push_back(1);
        if (s2 != t1) fl.push_back(0);
      end
      cls_ref = 0; flips_seen = 0;
      for (int h = 0; h < fl.size(); h++) begin
        int want;
        if (h > 0 && fl[h]) flips_seen++;
        want = (h == 0) ? 0 : (p ? flips_seen : h);
        drive(1, h == 0, fl[h], cls_ref);
        do begin
          maybe_tail();
          cycle();
        end while (!last_grant);
        held.push_back(last_chan);
        chk(last_cls == want, p ? (fl[h] ? "R4" : "R3") : "R2",
            "route class vs hop count", last_cls, want);
        cls_ref = want;
      end
      tvalid = 0;
      drive(0, 0, 0, 0);
      if (($urandom % 2) == 0) begin
        maybe_tail();
        cycle();
      end
    end
    tvalid = 0;
    release_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    total = 0; failed = 0;
    for (int i = 0; i < 6; i++) res[i] = 0;
    rst_n = 0; pol = 1; tvalid = 0; tvc = 0;
    drive(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(grant_valid === 1'b0 && stall === 1'b0, "R9", "idle in reset",
        int'(grant_valid) + int'(stall), 0);
    rst_n = 1;
    @(negedge clk);
    cycle();

    // Bridge-crossing rule: class 0 holds channels 0..2.
    pol = 1;
    for (int k = 0; k < 3; k++) begin
      drive(1, 1, 1, 1);
      cycle();
      chk(act_grant && act_chan == k, "R6", "lowest free on injection", act_chan, k);
    end
    drive(1, 1, 0, 0);
    cycle();
    chk(act_stall == 1, "R7", "stall when class full", int'(act_stall), 1);
    tvalid = 1; tvc = 3'd1;
    cycle();
    chk(act_stall == 1, "R8", "tail frees only after the edge", int'(act_stall), 1);
    tvalid = 0;
    cycle();
    chk(act_grant && act_chan == 1 && act_vc == 1, "R8", "freed channel regranted", act_chan, 1);
    drive(1, 0, 1, 0);
    cycle();
    chk(act_grant && act_chan == 3, "R4", "joining hop moves to class 1", act_chan, 3);
    drive(1, 0, 0, 1);
    cycle();
    chk(act_grant && act_chan == 4, "R3", "plain hop keeps class 1", act_chan, 4);
    drive(1, 0, 1, 1);
    cycle();
    chk(act_stall && !act_grant, "R5", "class 2 beyond bridge rule", int'(act_stall), 1);
    held.push_back(0); held.push_back(1); held.push_back(2);
    held.push_back(3); held.push_back(4);
    release_all();

    // Per-hop rule: three classes of two channels.
    pol = 0;
    drive(1, 0, 0, 2);
    cycle();
    chk(act_stall && !act_grant, "R5", "class 3 beyond per-hop rule", int'(act_stall), 1);
    drive(1, 0, 0, 1);
    cycle();
    chk(act_grant && act_chan == 4 && act_vc == 0, "R2", "third hop in class 2", act_chan, 4);
    drive(1, 0, 1, 0);
    cycle();
    chk(act_grant && act_chan == 2, "R2", "second hop in class 1", act_chan, 2);
    drive(1, 1, 1, 2);
    cycle();
    chk(act_grant && act_chan == 0, "R1", "injection ignores class and flag", act_chan, 0);
    held.push_back(4); held.push_back(2); held.push_back(0);
    release_all();

    run_routes(0, 250);
    run_routes(1, 250);
    run_routes(0, 150);

    report();
    $finish;
  end

endmodule